// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns an already-conditioned three-level switching command into the two gate enables of a synchronous buck power stage. The command can ask for the high-side switch, for the low-side switch, or for neither (a released, mid-level input). Before either gate is allowed to rise, the block waits until the opposite gate is sensed as discharged, using a comparator flag from the gate itself. It then adds a fixed propagation delay. The switch node is never consulted, so the low-side switch always comes on and can sink current.

Four qualifiers sit above the sequencing:
- **Stage enable:** filtered so that a short pulse does nothing.
- **Low-side skip:** keeps the low-side switch off for diode-emulation light-load operation.
- **Logic-supply lockout:** has hysteresis between a falling and a rising comparator.
- **Bootstrap-supply flag:** blocks high-side turn-on.

All delays are counts of a 200 MHz clock (5 ns per cycle). Reset forces both gates off.

Top module: `deadtime_gate_seq`

## Requirements
- R1: `gh_en_o` and `gl_en_o` are never high in the same cycle.
- R2: With `cmd_i`=2'b00 (low), a high `gh_en_o` falls on the HS_OFF_DLY-th (4th) clock edge after the command. Once `gh_en_o` is low and `hs_gate_low_i` is high, `gl_en_o` rises on the LS_ON_DLY-th (4th) edge. No switch-node input exists.
- R3: With `cmd_i`=2'b01 (high), a high `gl_en_o` falls on the LS_OFF_DLY-th (2nd) edge. Once `gl_en_o` is low and `ls_gate_low_i` is high, `gh_en_o` rises on the HS_ON_DLY-th (3rd) edge.
- R4: `cmd_i`=2'b10 (released) or the unused code 2'b11 drives both gates low at the next clock edge.
- R5: `stage_en_i` low for EN_DLY (3) consecutive cycles turns the stage off, and both gates are low one edge later. A low pulse shorter than EN_DLY cycles has no effect. Turn-on is filtered in the same way.
- R6: `ls_skip_ni` low forces `gl_en_o` low at the next edge and keeps it low. `gh_en_o` keeps following the command.
- R7: `vcin_fall_ok_i` low drives both gates low by the second clock edge. The lockout is released only when `vcin_rise_ok_i` is high. Between the two thresholds (`vcin_rise_ok_i` low, `vcin_fall_ok_i` high) the current lockout state holds.
- R8: `boot_ok_i` low prevents `gh_en_o` from rising.
- R9: `rst_ni` low asynchronously forces both gates low. After release, the stage is off until the enable filter has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 200 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Switching command: 00 low side, 01 high side, 10/11 released |
| hs_gate_low_i | input | 1 | High-side gate sensed below its off threshold |
| ls_gate_low_i | input | 1 | Low-side gate sensed below its off threshold |
| stage_en_i | input | 1 | Stage enable, low (or undriven, resolved low upstream) shuts the stage |
| ls_skip_ni | input | 1 | Low-side skip, active low |
| vcin_rise_ok_i | input | 1 | Logic supply above the rising lockout threshold |
| vcin_fall_ok_i | input | 1 | Logic supply above the falling lockout threshold |
| boot_ok_i | input | 1 | Bootstrap supply sufficient for high-side turn-on |
| gh_en_o | output | 1 | High-side gate enable |
| gl_en_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume the command and qualifier inputs are settled at each clock edge, and that the gate-sensing flags come from real gate behaviour. In practice this means a gate's "low" flag is high whenever that gate has been off for a cycle.

The bench keeps within these assumptions:
- It changes inputs only on the falling clock edge.
- It models each sensing flag as the inverse of the matching gate enable, delayed by one register. A gate is therefore sensed discharged exactly one cycle after its enable drops.
- It never drives `vcin_rise_ok_i` high while `vcin_fall_ok_i` is low, except to release a lockout.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_REL  = 2'b10
  } cmd_e;

  // timer slots
  localparam int unsigned TMR_HS_OFF = 0;
  localparam int unsigned TMR_LS_ON  = 1;
  localparam int unsigned TMR_LS_OFF = 2;
  localparam int unsigned TMR_HS_ON  = 3;
  localparam int unsigned TMR_EN     = 4;
  localparam int unsigned NUM_TMR    = 5;
endpackage

// File: rtl/gs_delay_timer.sv
// fire_o goes high in the N-th consecutive cycle that arm_i is held
module gs_delay_timer #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic fire_o
);
  localparam int unsigned W    = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  assign fire_o = arm_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!arm_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gs_supply_lockout.sv
// hysteretic lockout: trips below the falling level, clears above the rising level
module gs_supply_lockout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_rise_i,
  input  logic above_fall_i,
  output logic ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ok_q <= 1'b0;
    else if (!above_fall_i) ok_q <= 1'b0;
    else if (above_rise_i)  ok_q <= 1'b1;
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq
  import gate_seq_pkg::*;
#(
  parameter int unsigned HS_OFF_DLY = 4,
  parameter int unsigned LS_ON_DLY  = 4,
  parameter int unsigned LS_OFF_DLY = 2,
  parameter int unsigned HS_ON_DLY  = 3,
  parameter int unsigned EN_DLY     = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       hs_gate_low_i,
  input  logic       ls_gate_low_i,
  input  logic       stage_en_i,
  input  logic       ls_skip_ni,
  input  logic       vcin_rise_ok_i,
  input  logic       vcin_fall_ok_i,
  input  logic       boot_ok_i,
  output logic       gh_en_o,
  output logic       gl_en_o
);
  localparam int unsigned DLY_TAB [NUM_TMR] =
    '{HS_OFF_DLY, LS_ON_DLY, LS_OFF_DLY, HS_ON_DLY, EN_DLY};

  logic [NUM_TMR-1:0] arm, fire;
  logic en_q, supply_ok, run;
  logic want_low, want_high;
  logic gh_q, gl_q, gh_d, gl_d;

  gs_supply_lockout u_lockout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .above_rise_i (vcin_rise_ok_i),
    .above_fall_i (vcin_fall_ok_i),
    .ok_o         (supply_ok)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    gs_delay_timer #(.N(DLY_TAB[i])) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm[i]),
      .fire_o (fire[i])
    );
  end

  assign run       = en_q && supply_ok;
  assign want_low  = run && (cmd_i == CMD_LOW);
  assign want_high = run && (cmd_i == CMD_HIGH);

  assign arm[TMR_EN]     = stage_en_i ^ en_q;
  assign arm[TMR_HS_OFF] = gh_q && want_low;
  assign arm[TMR_LS_ON]  = !gh_q && !gl_q && hs_gate_low_i && want_low && ls_skip_ni;
  assign arm[TMR_LS_OFF] = gl_q && want_high && ls_skip_ni;
  assign arm[TMR_HS_ON]  = !gh_q && !gl_q && ls_gate_low_i && want_high && boot_ok_i;

  always_comb begin
    gh_d = gh_q;
    if (!want_low && !want_high)  gh_d = 1'b0;  // released, disabled or locked out
    else if (fire[TMR_HS_OFF])    gh_d = 1'b0;
    else if (fire[TMR_HS_ON])     gh_d = 1'b1;
  end

  always_comb begin
    gl_d = gl_q;
    if ((!want_low && !want_high) || !ls_skip_ni) gl_d = 1'b0;
    else if (fire[TMR_LS_OFF])                    gl_d = 1'b0;
    else if (fire[TMR_LS_ON])                     gl_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      gh_q <= 1'b0;
      gl_q <= 1'b0;
    end else begin
      if (fire[TMR_EN]) en_q <= stage_en_i;
      gh_q <= gh_d;
      gl_q <= gl_d;
    end
  end

  assign gh_en_o = gh_q;
  assign gl_en_o = gl_q;
endmodule

// File: rtl/deadtime_gate_seq_chk.sv
module deadtime_gate_seq_chk
  import gate_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cmd_i,
  input logic       hs_gate_low_i,
  input logic       ls_gate_low_i,
  input logic       ls_skip_ni,
  input logic       vcin_fall_ok_i,
  input logic       boot_ok_i,
  input logic       gh_en_o,
  input logic       gl_en_o
);
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gh_en_o && gl_en_o)); // R1

  AST_GL_RISE_AFTER_HS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gl_en_o) |-> ($past(hs_gate_low_i) && $past(cmd_i) == CMD_LOW)); // R2

  AST_GH_RISE_AFTER_LS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gh_en_o) |-> ($past(ls_gate_low_i) && $past(cmd_i) == CMD_HIGH)); // R3

  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i[1] |=> (!gh_en_o && !gl_en_o)); // R4

  AST_SKIP_HOLDS_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_skip_ni |=> !gl_en_o); // R6

  AST_UVLO_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vcin_fall_ok_i && $past(!vcin_fall_ok_i)) |=> (!gh_en_o && !gl_en_o)); // R7

  AST_BOOT_BLOCKS_GH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gh_en_o) |-> $past(boot_ok_i)); // R8
endmodule

bind deadtime_gate_seq deadtime_gate_seq_chk u_chk (.*);

// File: tb/deadtime_gate_seq_test.sv
module deadtime_gate_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cmd_i = 2'b10;
  logic       hs_gate_low_i = 1'b1;
  logic       ls_gate_low_i = 1'b1;
  logic       stage_en_i = 1'b0;
  logic       ls_skip_ni = 1'b1;
  logic       vcin_rise_ok_i = 1'b0;
  logic       vcin_fall_ok_i = 1'b0;
  logic       boot_ok_i = 1'b1;
  logic       gh_en_o, gl_en_o;

  int errors = 0;
  int checks = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  deadtime_gate_seq uut (.*);

  // gate sensing model: a gate reads as discharged one cycle after its enable drops
  always @(posedge clk_i) begin
    hs_gate_low_i <= !gh_en_o;
    ls_gate_low_i <= !gl_en_o;
  end

  always @(negedge clk_i) if (gh_en_o && gl_en_o) overlap++;

  // row: cmd[17:16] en[15] skip_n[14] boot[13] rise[12] fall[11] wait[10:6] gh[5] gl[4] req[3:0]
  localparam int NV = 39;
  localparam logic [17:0] VEC [NV] = '{
    // R2 start-up towards low side
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd6,1'b0,1'b0,4'd2},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b1,4'd2},
    // R3 low -> high
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b1,4'd3},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd3},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd3,1'b0,1'b0,4'd3},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b1,1'b0,4'd3},
    // R2 high -> low
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd3,1'b1,1'b0,4'd2},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd2},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd4,1'b0,1'b0,4'd2},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b1,4'd2},
    // R4 release from low side
    {2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd4},
    {2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,5'd5,1'b0,1'b0,4'd4},
    // R3 high from released
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd2,1'b0,1'b0,4'd3},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b1,1'b0,4'd3},
    // R4 unused code from high side
    {2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd4},
    // R6 skip
    {2'b00,1'b1,1'b0,1'b1,1'b1,1'b1,5'd10,1'b0,1'b0,4'd6},
    {2'b01,1'b1,1'b0,1'b1,1'b1,1'b1,5'd3,1'b1,1'b0,4'd6},
    {2'b00,1'b1,1'b0,1'b1,1'b1,1'b1,5'd4,1'b0,1'b0,4'd6},
    {2'b00,1'b1,1'b0,1'b1,1'b1,1'b1,5'd10,1'b0,1'b0,4'd6},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd3,1'b0,1'b0,4'd6},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b1,4'd6},
    {2'b00,1'b1,1'b0,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd6},
    // R8 bootstrap
    {2'b01,1'b1,1'b1,1'b0,1'b1,1'b1,5'd10,1'b0,1'b0,4'd8},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd2,1'b0,1'b0,4'd8},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b1,1'b0,4'd8},
    // R5 enable filter
    {2'b01,1'b0,1'b1,1'b1,1'b1,1'b1,5'd3,1'b1,1'b0,4'd5},
    {2'b01,1'b0,1'b1,1'b1,1'b1,1'b1,5'd1,1'b0,1'b0,4'd5},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd5,1'b0,1'b0,4'd5},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b1,1'b0,4'd5},
    {2'b01,1'b0,1'b1,1'b1,1'b1,1'b1,5'd2,1'b1,1'b0,4'd5},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd5,1'b1,1'b0,4'd5},
    // R7 logic-supply lockout and hysteresis
    {2'b01,1'b1,1'b1,1'b1,1'b0,1'b0,5'd1,1'b1,1'b0,4'd7},
    {2'b01,1'b1,1'b1,1'b1,1'b0,1'b0,5'd1,1'b0,1'b0,4'd7},
    {2'b01,1'b1,1'b1,1'b1,1'b0,1'b1,5'd8,1'b0,1'b0,4'd7},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd3,1'b0,1'b0,4'd7},
    {2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,5'd1,1'b1,1'b0,4'd7},
    {2'b01,1'b1,1'b1,1'b1,1'b0,1'b1,5'd8,1'b1,1'b0,4'd7},
    {2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,5'd20,1'b0,1'b1,4'd2},
    {2'b00,1'b1,1'b1,1'b1,1'b0,1'b0,5'd2,1'b0,1'b0,4'd7}
  };

  task automatic check(input string tag, input logic gh_exp, input logic gl_exp);
    checks++;
    if (gh_en_o !== gh_exp || gl_en_o !== gl_exp) begin
      errors++;
      $display("FAIL %s: gh/gl actual %b%b expected %b%b at %0t",
               tag, gh_en_o, gl_en_o, gh_exp, gl_exp, $time);
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk_i);
    check("R9 reset", 1'b0, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      cmd_i          = v[17:16];
      stage_en_i     = v[15];
      ls_skip_ni     = v[14];
      boot_ok_i      = v[13];
      vcin_rise_ok_i = v[12];
      vcin_fall_ok_i = v[11];
      repeat (int'(v[10:6])) @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d row %0d", v[3:0], i), v[5], v[4]);
    end
    // R9: asynchronous reset mid-run with the low side on
    cmd_i = 2'b00; vcin_rise_ok_i = 1'b1; vcin_fall_ok_i = 1'b1;
    repeat (20) @(negedge clk_i);
    check("R2 low side restored", 1'b0, 1'b1);
    #1 rst_ni = 1'b0;
    #0.5 check("R9 async reset", 1'b0, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9 enable filter after reset", 1'b0, 1'b0);
    // R1: no overlap seen across the whole run
    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R1: overlap cycles actual %0d expected 0", overlap);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule